// File: doc/BRIEF.md
# Temperature alarm window comparator

This block watches a stream of signed temperature samples and reports where each one falls relative to three programmable limits: an upper window limit, a lower window limit and a critical limit. Each limit drives a status flag. A flag sets as soon as its trip point is crossed. It releases only once the temperature has moved back past the limit by a selectable hysteresis margin. The three flags and a polarity-adjustable event output are registered and refresh only when a new sample arrives.

Limits and a 16-bit configuration word are programmed through a simple word-wide write port. All registers and the most recent sample, together with its flags, can be read back one cycle after the address is presented. The configuration word holds two lock bits. One freezes the window limits and the other freezes the critical limit. While either lock bit is set, the hysteresis selection is frozen too, so limits that have been secured cannot be loosened indirectly.

Temperatures and limits are two's-complement numbers with a 0.25 °C LSB. All comparisons are signed.

Top module: `thermal_window_monitor`

## Requirements
- R1: After reset every register reads 0. Configuration bits 15:11 always read 0 whatever is written. Bits 10:0 read back as written, except where R10 blocks the change.
- R2: Configuration bits 10:9 select the hysteresis margin: 00 gives 0, 01 gives 6 LSB (1.5 °C), 10 gives 12 LSB (3 °C) and 11 gives 24 LSB (6 °C).
- R3: On a sample, the above flag becomes 1 when the temperature is strictly greater than the upper limit.
- R4: Once set, the above flag stays 1 until a sample is less than or equal to the upper limit minus the margin.
- R5: On a sample, the below flag becomes 0 when the temperature is greater than or equal to the lower limit. This clear condition wins over the set condition.
- R6: The below flag becomes 1 when a sample is less than or equal to the lower limit minus the margin. Between the two thresholds it keeps its value.
- R7: The critical flag sets when a sample is strictly greater than the critical limit. It clears when a sample is less than or equal to the critical limit minus the margin.
- R8: All flags reset to 0 and change only on the clock edge that takes a sample strobe. With no strobe they hold, whatever the temperature input does.
- R9: The event output is registered and equals (above OR below OR critical) XOR configuration bit 1 (polarity). A polarity change shows up one cycle after the write takes effect.
- R10: While configuration bit 6 (window lock) is 1, writes to the upper and lower limits are ignored. While bit 7 (critical lock) is 1, writes to the critical limit are ignored. While either lock bit is 1, bits 10:9 cannot change. The lock bits themselves stay writable.
- R11: The read data is registered and reflects the address of the previous cycle. Address 1 is the configuration word, 2 the upper limit, 3 the lower limit and 4 the critical limit (each of the limits in bits 12:0 with the upper bits 0). Address 5 is the status word: bit 15 critical, bit 14 above, bit 13 below, bits 12:0 the last sample. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | Sample strobe |
| samp_temp | input | TW (13) | Signed temperature sample, 0.25 °C LSB |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW (3) | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| above_o | output | 1 | Temperature above window |
| below_o | output | 1 | Temperature below window |
| crit_o | output | 1 | Temperature above critical limit |
| event_o | output | 1 | Event output, polarity-adjusted |

## Verification
The flags, the captured sample and the event output all change on the same rising edge that takes the strobe, so their values are due one cycle after a strobe. The bench drives each stimulus on a falling edge and reads the results at the next falling edge. Register writes also land on one edge. A polarity change reaches the event output one edge later still, so the bench waits a second cycle before it checks the event. A readback is due one edge after its address is driven and is sampled at the falling edge that follows.

// File: rtl/twm_pkg.sv
package twm_pkg;

  localparam int CFG_W  = 16;
  localparam int STAT_W = 13;

  localparam logic [2:0] A_CFG   = 3'd1;
  localparam logic [2:0] A_UPPER = 3'd2;
  localparam logic [2:0] A_LOWER = 3'd3;
  localparam logic [2:0] A_CRIT  = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;

  localparam int B_HYST_LO = 9;
  localparam int B_HYST_HI = 10;
  localparam int B_CLOCK   = 7;
  localparam int B_WLOCK   = 6;
  localparam int B_POL     = 1;

  localparam logic [CFG_W-1:0] CFG_MASK = 16'h07FF;

  localparam int F_ABOVE = 0;
  localparam int F_BELOW = 1;
  localparam int F_CRIT  = 2;
  localparam int NFLAG   = 3;

  // margin in LSBs: 1.5, 3 and 6 degrees expressed with frac fraction bits
  function automatic int unsigned hyst_steps(input logic [1:0] sel, input int unsigned frac);
    case (sel)
      2'b01:   return 32'd3 << (frac - 1);
      2'b10:   return 32'd3 << frac;
      2'b11:   return 32'd3 << (frac + 1);
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/twm_regs.sv
module twm_regs
  import twm_pkg::*;
#(
  parameter int TW = 13,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [CFG_W-1:0]     wdata,
  output logic [CFG_W-1:0]     cfg,
  output logic signed [TW-1:0] lim_hi,
  output logic signed [TW-1:0] lim_lo,
  output logic signed [TW-1:0] lim_crit
);

  logic [CFG_W-1:0] cfg_wr;
  logic             any_lock;

  assign any_lock = cfg[B_WLOCK] | cfg[B_CLOCK];

  always_comb begin
    cfg_wr = wdata & CFG_MASK;
    if (any_lock) begin
      cfg_wr[B_HYST_HI:B_HYST_LO] = cfg[B_HYST_HI:B_HYST_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      lim_hi   <= '0;
      lim_lo   <= '0;
      lim_crit <= '0;
    end else if (we) begin
      case (addr)
        AW'(A_CFG):   cfg <= cfg_wr;
        AW'(A_UPPER): if (!cfg[B_WLOCK]) lim_hi   <= wdata[TW-1:0];
        AW'(A_LOWER): if (!cfg[B_WLOCK]) lim_lo   <= wdata[TW-1:0];
        AW'(A_CRIT):  if (!cfg[B_CLOCK]) lim_crit <= wdata[TW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twm_hyst_cmp.sv
module twm_hyst_cmp
  import twm_pkg::*;
#(
  parameter int   TW       = 13,
  parameter int   FRAC     = 2,
  parameter logic LOW_SIDE = 1'b0
) (
  input  logic signed [TW-1:0] temp_i,
  input  logic signed [TW-1:0] limit_i,
  input  logic [1:0]           hsel_i,
  input  logic                 cur_i,
  output logic                 nxt_o
);

  localparam int EW = TW + 2;

  logic signed [EW-1:0] t_e;
  logic signed [EW-1:0] l_e;
  logic signed [EW-1:0] h_e;
  logic signed [EW-1:0] thr;

  assign t_e = EW'(temp_i);
  assign l_e = EW'(limit_i);
  assign h_e = EW'(hyst_steps(hsel_i, FRAC));
  assign thr = l_e - h_e;

  generate
    if (LOW_SIDE) begin : g_low
      always_comb begin
        if (t_e >= l_e)      nxt_o = 1'b0;
        else if (t_e <= thr) nxt_o = 1'b1;
        else                 nxt_o = cur_i;
      end
    end else begin : g_high
      always_comb begin
        if (t_e > l_e)       nxt_o = 1'b1;
        else if (t_e <= thr) nxt_o = 1'b0;
        else                 nxt_o = cur_i;
      end
    end
  endgenerate

endmodule

// File: rtl/thermal_window_monitor.sv
module thermal_window_monitor
  import twm_pkg::*;
#(
  parameter int TW   = 13,
  parameter int FRAC = 2,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 samp_vld,
  input  logic signed [TW-1:0] samp_temp,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [CFG_W-1:0]     reg_wdata,
  output logic [CFG_W-1:0]     reg_rdata,
  output logic                 above_o,
  output logic                 below_o,
  output logic                 crit_o,
  output logic                 event_o
);

  localparam int PAD = CFG_W - TW;

  logic [CFG_W-1:0]     cfg;
  logic signed [TW-1:0] lim_hi;
  logic signed [TW-1:0] lim_lo;
  logic signed [TW-1:0] lim_crit;
  logic signed [TW-1:0] lim_arr [NFLAG];
  logic [NFLAG-1:0]     flag_q;
  logic [NFLAG-1:0]     flag_nxt;
  logic [NFLAG-1:0]     flag_sel;
  logic signed [TW-1:0] last_temp;
  logic signed [STAT_W-1:0] temp_x;
  logic [CFG_W-1:0]     rd_nxt;

  twm_regs #(.TW(TW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cfg      (cfg),
    .lim_hi   (lim_hi),
    .lim_lo   (lim_lo),
    .lim_crit (lim_crit)
  );

  assign lim_arr[F_ABOVE] = lim_hi;
  assign lim_arr[F_BELOW] = lim_lo;
  assign lim_arr[F_CRIT]  = lim_crit;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_cmp
      twm_hyst_cmp #(
        .TW       (TW),
        .FRAC     (FRAC),
        .LOW_SIDE (i == F_BELOW)
      ) u_cmp (
        .temp_i  (samp_temp),
        .limit_i (lim_arr[i]),
        .hsel_i  (cfg[B_HYST_HI:B_HYST_LO]),
        .cur_i   (flag_q[i]),
        .nxt_o   (flag_nxt[i])
      );
    end
  endgenerate

  assign flag_sel = samp_vld ? flag_nxt : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      last_temp <= '0;
      event_o   <= 1'b0;
    end else begin
      if (samp_vld) begin
        flag_q    <= flag_nxt;
        last_temp <= samp_temp;
      end
      event_o <= (|flag_sel) ^ cfg[B_POL];
    end
  end

  assign above_o = flag_q[F_ABOVE];
  assign below_o = flag_q[F_BELOW];
  assign crit_o  = flag_q[F_CRIT];

  assign temp_x = STAT_W'(last_temp);

  always_comb begin
    case (reg_addr)
      AW'(A_CFG):   rd_nxt = cfg;
      AW'(A_UPPER): rd_nxt = {{PAD{1'b0}}, lim_hi};
      AW'(A_LOWER): rd_nxt = {{PAD{1'b0}}, lim_lo};
      AW'(A_CRIT):  rd_nxt = {{PAD{1'b0}}, lim_crit};
      AW'(A_STAT):  rd_nxt = {flag_q[F_CRIT], flag_q[F_ABOVE], flag_q[F_BELOW], temp_x};
      default:      rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

endmodule

// File: rtl/twm_checker.sv
module twm_checker
  import twm_pkg::*;
#(
  parameter int TW = 13,
  parameter int AW = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 samp_vld,
  input logic signed [TW-1:0] samp_temp,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [CFG_W-1:0]     reg_rdata,
  input logic                 above_o,
  input logic                 below_o,
  input logic                 crit_o,
  input logic                 event_o,
  input logic [CFG_W-1:0]     cfg,
  input logic signed [TW-1:0] lim_hi,
  input logic signed [TW-1:0] lim_lo,
  input logic signed [TW-1:0] lim_crit
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(A_CFG)) |=> (reg_rdata[15:11] == 5'd0)); // R1

  AST_ABOVE_SET: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && (samp_temp > lim_hi)) |=> above_o); // R3

  AST_BELOW_CLR: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && (samp_temp >= lim_lo)) |=> !below_o); // R5

  AST_CRIT_SET: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && (samp_temp > lim_crit)) |=> crit_o); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !samp_vld |=> ($stable(above_o) && $stable(below_o) && $stable(crit_o))); // R8

  AST_EVENT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (event_o == ((above_o | below_o | crit_o) ^ $past(cfg[B_POL])))); // R9

  AST_WLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && cfg[B_WLOCK] && (reg_addr == AW'(A_UPPER) || reg_addr == AW'(A_LOWER)))
      |=> ($stable(lim_hi) && $stable(lim_lo))); // R10

  AST_CLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && cfg[B_CLOCK] && (reg_addr == AW'(A_CRIT))) |=> $stable(lim_crit)); // R10

endmodule

bind thermal_window_monitor twm_checker #(.TW(TW), .AW(AW)) u_chk (.*);

// File: tb/thermal_window_monitor_bench.sv
`timescale 1ns/1ps
module thermal_window_monitor_bench;

  localparam int TW = 13;
  localparam int AW = 3;
  localparam int NV = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              samp_vld = 1'b0;
  logic signed [TW-1:0] samp_temp = '0;
  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              above_o, below_o, crit_o, event_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] rd_val;

  always #10 clk = ~clk;

  thermal_window_monitor u_thermal_window_monitor (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .samp_temp(samp_temp),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .above_o(above_o), .below_o(below_o), .crit_o(crit_o), .event_o(event_o)
  );

  // {temperature, above, below, critical}; upper 320, lower 80, critical 400, margin 12
  localparam logic [18:0] VEC [NV] = '{
    {16'd200, 3'b000}, {16'd321, 3'b100}, {16'd320, 3'b100}, {16'd309, 3'b100},
    {16'd308, 3'b000}, {16'd80,  3'b000}, {16'd79,  3'b000}, {16'd68,  3'b010},
    {16'd75,  3'b010}, {16'd80,  3'b000}, {16'd401, 3'b101}, {16'd395, 3'b101},
    {16'd388, 3'b100}, {16'hFFD8, 3'b010}, {16'd200, 3'b000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    rd_val = reg_rdata;
  endtask

  task automatic samp(input logic [15:0] t);
    @(negedge clk);
    samp_vld = 1'b1; samp_temp = t[TW-1:0];
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic chk_flags(input string req, input logic [2:0] exp);
    check(req, {13'd0, above_o, below_o, crit_o}, {13'd0, exp});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 R8 R9: reset state
    chk_flags("R8 reset flags", 3'b000);
    check("R9 reset event", {15'd0, event_o}, 16'd0);
    rd(3'd1);
    check("R1 reset cfg", rd_val, 16'h0000);

    wr(3'd2, 16'd320);
    wr(3'd3, 16'd80);
    wr(3'd4, 16'd400);
    wr(3'd1, 16'h0400);

    // R3 R4 R5 R6 R7 R9: vector walk
    for (int i = 0; i < NV; i++) begin
      samp(VEC[i][18:3]);
      chk_flags($sformatf("R3/R4/R5/R6/R7 vector %0d", i), VEC[i][2:0]);
      check($sformatf("R9 event vector %0d", i), {15'd0, event_o}, {15'd0, |VEC[i][2:0]});
    end

    // R11: status word after sample 200
    rd(3'd5);
    check("R11 status word", rd_val, 16'h00C8);

    // R8: no strobe, no change
    @(negedge clk); samp_temp = 13'd500;
    repeat (4) @(negedge clk);
    chk_flags("R8 hold without strobe", 3'b000);

    samp(16'd500);
    chk_flags("R3 R7 at 500", 3'b101);
    rd(3'd5);
    check("R11 status word flags", rd_val, 16'hC1F4);

    // R9: polarity
    wr(3'd1, 16'h0402);
    @(negedge clk);
    check("R9 inverted active", {15'd0, event_o}, 16'd0);
    samp(16'd200);
    check("R9 inverted idle", {15'd0, event_o}, 16'd1);
    wr(3'd1, 16'h0400);
    @(negedge clk);
    check("R9 normal idle", {15'd0, event_o}, 16'd0);

    // R1: reserved bits
    wr(3'd1, 16'hFC00);
    rd(3'd1);
    check("R1 reserved bits", rd_val, 16'h0400);
    wr(3'd1, 16'h013D);
    rd(3'd1);
    check("R1 readback", rd_val, 16'h013D);

    // R2: margin 0
    wr(3'd1, 16'h0000);
    samp(16'd321); chk_flags("R2 no margin set", 3'b100);
    samp(16'd320); chk_flags("R2 no margin clear", 3'b000);
    samp(16'd79);  chk_flags("R6 no margin below", 3'b010);
    samp(16'd80);  chk_flags("R5 no margin clear", 3'b000);

    // R2: margin 24
    wr(3'd1, 16'h0600);
    samp(16'd321); chk_flags("R2 wide margin set", 3'b100);
    samp(16'd297); chk_flags("R2 wide margin hold", 3'b100);
    samp(16'd296); chk_flags("R2 wide margin clear", 3'b000);

    // R10: locks
    wr(3'd1, 16'h0640);
    wr(3'd2, 16'd100);
    rd(3'd2); check("R10 upper locked", rd_val, 16'd320);
    wr(3'd3, 16'd0);
    rd(3'd3); check("R10 lower locked", rd_val, 16'd80);
    wr(3'd1, 16'h0040);
    rd(3'd1); check("R10 margin frozen", rd_val, 16'h0640);
    wr(3'd4, 16'd410);
    rd(3'd4); check("R10 critical open", rd_val, 16'd410);
    wr(3'd1, 16'h06C0);
    wr(3'd4, 16'd300);
    rd(3'd4); check("R10 critical locked", rd_val, 16'd410);
    wr(3'd1, 16'h0000);
    rd(3'd1); check("R10 unlock keeps margin", rd_val, 16'h0600);
    wr(3'd2, 16'd100);
    rd(3'd2); check("R10 upper after unlock", rd_val, 16'd100);
    rd(3'd7); check("R11 unmapped", rd_val, 16'd0);

    // R8: reset mid-run
    samp(16'd500);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_flags("R8 flags after reset", 3'b000);
    rd(3'd2); check("R1 limit after reset", rd_val, 16'd0);

    finish_run();
  end

endmodule